// File: doc/BRIEF.md
# Debug Recovery Sequence Monitor

This block watches the protocol-switch activity on a debug port while the device reset pin is held asserted. An external decoder turns each recognised switch bit pattern into a one-cycle pulse, one line for a switch from JTAG to SWD and one for a switch from SWD to JTAG. The monitor counts a series of these pulses that alternates strictly and begins with a JTAG-to-SWD switch. When the series reaches its full length, the monitor asks the flash controller for a mass erase.

Once the erase is reported finished, the monitor asks for the nonvolatile configuration registers to be put back to their factory values. It then waits until the device reset is released before it can arm again. A busy flag covers the whole erase and restore phase.

The series length is `SEQ_LEN` events and must be odd, so that the series both starts and ends with a JTAG-to-SWD switch. The default is nine events: five switches to SWD and four switches back to JTAG.

Top module: `recovery_seq_monitor`

## Requirements
- R1: After `rst_ni` is applied, `erase_req_o`, `restore_req_o` and `busy_o` are all 0.
- R2: Switch pulses are counted only while `dev_rst_i` is 1. A complete series sent while `dev_rst_i` is 0 raises no erase request.
- R3: `SEQ_LEN` pulses (default 9) that alternate strictly and start with JTAG-to-SWD (`j2s_i`) raise `erase_req_o` on the cycle after the last pulse. One pulse fewer does not raise it.
- R4: A pulse out of order clears the count to zero. This covers `s2j_i` as the first pulse, the same type twice in a row, and both lines high in the same cycle. When the offending pulse is a lone `j2s_i`, the count restarts at one.
- R5: Driving `dev_rst_i` low before the series completes clears the count. Events sent after `dev_rst_i` returns must form a full new series.
- R6: `erase_req_o` stays 1 until `erase_done_i` is sampled 1. On the next cycle `erase_req_o` is 0 and `restore_req_o` is 1. `restore_req_o` never rises without an erase just before it.
- R7: `restore_req_o` stays 1 until `restore_done_i` is sampled 1. The monitor then holds all outputs at 0 and ignores pulses until `dev_rst_i` goes to 0. After that it can arm again.
- R8: Switch pulses arriving while an erase or restore is requested do not change `erase_req_o`, `restore_req_o` or `busy_o`.
- R9: `busy_o` is 1 from the cycle `erase_req_o` rises through the last cycle of `restore_req_o`, and 0 otherwise.
- R10: `erase_req_o` and `restore_req_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the monitor |
| dev_rst_i | input | 1 | Device reset pin level, 1 = held in reset |
| j2s_i | input | 1 | One-cycle pulse: JTAG-to-SWD switch decoded |
| s2j_i | input | 1 | One-cycle pulse: SWD-to-JTAG switch decoded |
| erase_done_i | input | 1 | Flash mass erase finished |
| restore_done_i | input | 1 | Nonvolatile register restore finished |
| erase_req_o | output | 1 | Mass erase request |
| restore_req_o | output | 1 | Factory restore request |
| busy_o | output | 1 | Erase or restore in progress |

## Verification
The hardest situation to reach from the ports is an out-of-order pulse that leaves a partial count behind, followed by a series that is exactly one event too short. The stimulus sweeps every prefix length from empty to one short of complete. After each prefix it injects each kind of fault: a wrong-type pulse, and both lines pulsed together. It then works out the remaining events arithmetically from the restart value (zero or one). It checks that the request stays low one event short and rises on the last event. Pulses are also injected while erase and restore are pending, and after completion while the device reset is still held.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_COUNT   = 3'd1,
    ST_ERASE   = 3'd2,
    ST_RESTORE = 3'd3,
    ST_DONE    = 3'd4
  } rsm_state_e;
endpackage

// File: rtl/rsm_event_tracker.sv
module rsm_event_tracker #(
  parameter int unsigned SEQ_LEN = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic j2s_i,
  input  logic s2j_i,
  output logic complete_o
);
  localparam int unsigned CNT_W = (SEQ_LEN > 2) ? $clog2(SEQ_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SEQ_LEN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic want_j2s, hit, miss, any_evt;

  // even count expects a JTAG-to-SWD switch next
  assign want_j2s = ~cnt_q[0];
  assign any_evt  = j2s_i | s2j_i;
  assign hit      = (j2s_i ^ s2j_i) & (want_j2s ? j2s_i : s2j_i);
  assign miss     = any_evt & ~hit;

  assign complete_o = armed_i & hit & (cnt_q == LAST_IDX);

  always_comb begin
    cnt_d = cnt_q;
    if (!armed_i)        cnt_d = '0;
    else if (complete_o) cnt_d = '0;
    else if (hit)        cnt_d = cnt_q + 1'b1;
    else if (miss)       cnt_d = (j2s_i & ~s2j_i) ? CNT_W'(1) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  initial begin
    AST_ODD_LEN: assert (SEQ_LEN % 2 == 1);  // R3
  end

  AST_CNT_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |=> cnt_q == '0);  // R5
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST_IDX);  // R3
  AST_BOTH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && j2s_i && s2j_i) |=> cnt_q == '0);  // R4
endmodule

// File: rtl/rsm_ctrl.sv
module rsm_ctrl
  import rsm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dev_rst_i,
  input  logic complete_i,
  input  logic erase_done_i,
  input  logic restore_done_i,
  output logic armed_o,
  output logic erase_req_o,
  output logic restore_req_o,
  output logic busy_o
);
  rsm_state_e state_q, state_d;

  assign armed_o = dev_rst_i & ((state_q == ST_IDLE) | (state_q == ST_COUNT));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (complete_i) state_d = ST_ERASE;
                  else if (dev_rst_i) state_d = ST_COUNT;
      ST_COUNT:   if (complete_i) state_d = ST_ERASE;
                  else if (!dev_rst_i) state_d = ST_IDLE;
      ST_ERASE:   if (erase_done_i) state_d = ST_RESTORE;
      ST_RESTORE: if (restore_done_i) state_d = ST_DONE;
      ST_DONE:    if (!dev_rst_i) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign erase_req_o   = (state_q == ST_ERASE);
  assign restore_req_o = (state_q == ST_RESTORE);
  assign busy_o        = erase_req_o | restore_req_o;

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(erase_req_o && restore_req_o));  // R10
  AST_ERASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_req_o && !erase_done_i) |=> erase_req_o);  // R6
  AST_RESTORE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_req_o && erase_done_i) |=> restore_req_o);  // R6
  AST_RESTORE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_req_o && !restore_done_i) |=> restore_req_o);  // R7
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && dev_rst_i) |=> !busy_o);  // R7
endmodule

// File: rtl/recovery_seq_monitor.sv
module recovery_seq_monitor #(
  parameter int unsigned SEQ_LEN = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dev_rst_i,
  input  logic j2s_i,
  input  logic s2j_i,
  input  logic erase_done_i,
  input  logic restore_done_i,
  output logic erase_req_o,
  output logic restore_req_o,
  output logic busy_o
);
  logic armed, complete;

  rsm_event_tracker #(.SEQ_LEN(SEQ_LEN)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .armed_i    (armed),
    .j2s_i      (j2s_i),
    .s2j_i      (s2j_i),
    .complete_o (complete)
  );

  rsm_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .dev_rst_i      (dev_rst_i),
    .complete_i     (complete),
    .erase_done_i   (erase_done_i),
    .restore_done_i (restore_done_i),
    .armed_o        (armed),
    .erase_req_o    (erase_req_o),
    .restore_req_o  (restore_req_o),
    .busy_o         (busy_o)
  );

  AST_ERASE_UNDER_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(erase_req_o) |-> $past(dev_rst_i));  // R2
  AST_RESTORE_AFTER_ERASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(restore_req_o) |-> $past(erase_req_o));  // R6
  AST_BUSY_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(restore_req_o));  // R9
endmodule

// File: tb/recovery_seq_monitor_test.sv
`timescale 1ns/1ps
module recovery_seq_monitor_test;
  localparam int N = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dev_rst = 1'b0, j2s = 1'b0, s2j = 1'b0, e_done = 1'b0, r_done = 1'b0;
  logic erase_req, restore_req, busy;
  int compared = 0, mismatched = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  recovery_seq_monitor #(.SEQ_LEN(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .dev_rst_i(dev_rst),
    .j2s_i(j2s), .s2j_i(s2j), .erase_done_i(e_done), .restore_done_i(r_done),
    .erase_req_o(erase_req), .restore_req_o(restore_req), .busy_o(busy)
  );

  task automatic check(string req, string what, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic outs(string req, logic e, logic r, logic b);
    check(req, "erase_req", erase_req, e);
    check(req, "restore_req", restore_req, r);
    check(req, "busy", busy, b);
  endtask

  // one pulse; returns at the next falling edge with outputs updated
  task automatic pulse(logic j, logic s);
    @(negedge clk); j2s = j; s2j = s;
    @(negedge clk); j2s = 1'b0; s2j = 1'b0;
  endtask

  // events with index idx: even index is JTAG-to-SWD
  task automatic send_series(int start_idx, int count);
    for (int i = 0; i < count; i++) begin
      if (((start_idx + i) % 2) == 0) pulse(1'b1, 1'b0);
      else pulse(1'b0, 1'b1);
    end
  endtask

  task automatic finish_handshake(string req);
    @(negedge clk); e_done = 1'b1;
    @(negedge clk); e_done = 1'b0;
    outs(req, 1'b0, 1'b1, 1'b1);
    @(negedge clk); r_done = 1'b1;
    @(negedge clk); r_done = 1'b0;
    outs(req, 1'b0, 1'b0, 1'b0);
    @(negedge clk); dev_rst = 1'b0;
    @(negedge clk); dev_rst = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    outs("R1", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    outs("R1", 1'b0, 1'b0, 1'b0);

    // R2: full series without device reset
    send_series(0, N);
    outs("R2", 1'b0, 1'b0, 1'b0);

    // R3: exact length, one short stays low
    dev_rst = 1'b1; @(negedge clk);
    send_series(0, N - 1);
    outs("R3", 1'b0, 1'b0, 1'b0);
    send_series(N - 1, 1);
    outs("R3", 1'b1, 1'b0, 1'b1);

    // R6 and R8: hold, pulses ignored during erase
    repeat (3) @(negedge clk);
    outs("R6", 1'b1, 1'b0, 1'b1);
    pulse(1'b1, 1'b0); pulse(1'b0, 1'b1); pulse(1'b1, 1'b1);
    outs("R8", 1'b1, 1'b0, 1'b1);
    @(negedge clk); r_done = 1'b1;  // wrong done, ignored
    @(negedge clk); r_done = 1'b0;
    outs("R6", 1'b1, 1'b0, 1'b1);
    @(negedge clk); e_done = 1'b1;
    @(negedge clk); e_done = 1'b0;
    outs("R6", 1'b0, 1'b1, 1'b1);
    // R7 and R8 during restore
    send_series(0, N);
    outs("R8", 1'b0, 1'b1, 1'b1);
    @(negedge clk); e_done = 1'b1;
    @(negedge clk); e_done = 1'b0;
    outs("R7", 1'b0, 1'b1, 1'b1);
    @(negedge clk); r_done = 1'b1;
    @(negedge clk); r_done = 1'b0;
    outs("R9", 1'b0, 1'b0, 1'b0);
    // R7: done state ignores a full series while reset held
    send_series(0, N);
    outs("R7", 1'b0, 1'b0, 1'b0);
    @(negedge clk); dev_rst = 1'b0;
    @(negedge clk); dev_rst = 1'b1;
    @(negedge clk);
    send_series(0, N);
    outs("R7", 1'b1, 1'b0, 1'b1);
    finish_handshake("R7");

    // R5: reset release mid-series
    send_series(0, 5);
    @(negedge clk); dev_rst = 1'b0;
    @(negedge clk); dev_rst = 1'b1;
    send_series(5, N - 5);
    outs("R5", 1'b0, 1'b0, 1'b0);
    send_series(0, N);
    outs("R5", 1'b1, 1'b0, 1'b1);
    finish_handshake("R5");

    // R4 sweep: prefix k, fault kind f (0 wrong type, 1 both lines)
    for (int k = 0; k < N; k++) begin
      for (int f = 0; f < 2; f++) begin
        int restart;
        send_series(0, k);
        if (f == 1) begin
          pulse(1'b1, 1'b1);
          restart = 0;
        end else if ((k % 2) == 0) begin
          pulse(1'b0, 1'b1);
          restart = 0;
        end else begin
          pulse(1'b1, 1'b0);
          restart = 1;
        end
        outs("R4", 1'b0, 1'b0, 1'b0);
        if (N - restart - 1 > 0) begin
          send_series(restart, N - restart - 1);
          outs("R4", 1'b0, 1'b0, 1'b0);
        end
        send_series(N - 1, 1);
        outs("R4", 1'b1, 1'b0, 1'b1);
        finish_handshake("R4");
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule